// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Target

This block models a byte-addressed non-volatile memory that sits on a two-wire serial bus as a target. It runs on a local system clock, oversamples the bus clock and data lines, recognises Start, repeated Start and Stop conditions, and answers only when the select byte carries the fixed memory type code and a chip address equal to its three strap inputs. Up to eight such targets can therefore share one bus.

After a write select, the bus controller sends a two-byte memory address followed by any number of data bytes. These bytes are stored within one 32-byte page. After a read select, the target returns bytes from its internal address pointer for as long as the controller acknowledges. A write-lock input blocks every change to the array. A Stop that ends a write which stored data starts a fixed busy period. During that period the target ignores selects. The only output is a pull-down enable for the shared open-drain data line.

Top module: `eeprom_2w_target`

## Requirements
- R1: A Start (data falling while the bus clock is high) aborts any transfer and waits for a select byte. A Stop (data rising while the bus clock is high) returns the target to standby, where bytes without a fresh Start are not acknowledged.
- R2: The select byte is sent MSB first. Bits 7:4 must be 1010 and bits 3:1 must equal `chip_sel_i[2:0]`. On a match the target pulls data low during the 9th clock. On a mismatch it never pulls data low until the next Start.
- R3: Bit 0 of the select byte chooses the direction: 0 starts an address phase, 1 starts returning data.
- R4: The memory address is 12 bits, sent as two bytes with the high byte first. Bits 7:4 of the high byte are ignored, and each address byte is acknowledged.
- R5: With the write lock low, each data byte of a write is acknowledged and stored at the current address.
- R6: During a write, only address bits 4:0 advance, wrapping within the 32-byte page. Bytes beyond 32 overwrite earlier bytes of the same page.
- R7: With `wr_lock_i` high, write data bytes are not acknowledged and the array keeps its contents.
- R8: A read select that follows a Start returns the byte at the internal pointer. The pointer is one past the last byte read, or it is the address most recently loaded.
- R9: A write select with an address, followed by a repeated Start and a read select, returns the byte at that address.
- R10: Reads continue while the controller acknowledges, with the address advancing and wrapping across all 12 bits. A controller non-acknowledge releases the bus until the next Start.
- R11: A Stop after a write that stored at least one byte starts a busy period of `BUSY_CYC` clocks. During it, select bytes are not acknowledged. A write that stored nothing starts no busy period.
- R12: `sda_pull_o` changes only in response to a bus clock falling edge, a Start or a Stop, never while the bus clock stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock level |
| sda_i | input | 1 | Resolved level of the shared data line |
| chip_sel_i | input | 3 | Strapped chip address compared with select bits 3:1 |
| wr_lock_i | input | 1 | High blocks all writes to the array |
| sda_pull_o | output | 1 | High pulls the open-drain data line low |

## Verification
The bench writes across a page end and past 32 bytes. It expects the wrapped bytes at the start of the same page, so a design that carries into the upper address bits would return data from the wrong page. A read that runs past address 0xFFF must come back at 0x000, and a byte clocked after the controller's non-acknowledge must read as all ones; a design that kept driving would corrupt it. The bench also selects a target that is still busy, writes under lock and then reads back the old byte, clocks a byte after a Stop without a Start, and uses select codes that differ only in the chip bits or only in the type code. Each of these catches a design that acknowledges where it should stay silent.

// File: rtl/eep_pkg.sv
// Shared types and constants for the serial EEPROM target.
// Assumes an 8-bit data path and a fixed 4-bit memory type code.
package eep_pkg;
    localparam int          BYTE_W   = 8;
    localparam logic [3:0]  DEV_TYPE = 4'b1010;

    typedef enum logic [2:0] {
        ST_IDLE,   // standby, bus released
        ST_DEV,    // receiving select byte
        ST_AHI,    // receiving high address byte
        ST_ALO,    // receiving low address byte
        ST_WDATA,  // receiving write data
        ST_RDATA   // transmitting read data
    } eep_state_t;
endpackage

// File: rtl/eep_bus_sense.sv
// Bus condition detector: synchronises the bus clock and data lines into
// the system clock domain and flags edges, Start and Stop as one-cycle
// pulses. Assumes the system clock is several times faster than the bus.
module eep_bus_sense (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    logic [2:0] scl_q;
    logic [2:0] sda_q;

    // Two-stage synchroniser plus one history stage per line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 3'b111;
            sda_q <= 3'b111;
        end else begin
            scl_q <= {scl_q[1:0], scl_i};
            sda_q <= {sda_q[1:0], sda_i};
        end
    end

    // Edge and condition decode on the synchronised samples.
    always_comb begin
        sda_o      = sda_q[1];
        scl_rise_o = scl_q[1] & ~scl_q[2];
        scl_fall_o = ~scl_q[1] & scl_q[2];
        start_o    = scl_q[1] & scl_q[2] & sda_q[2] & ~sda_q[1];
        stop_o     = scl_q[1] & scl_q[2] & ~sda_q[2] & sda_q[1];
    end
endmodule

// File: rtl/eep_busy_timer.sv
// Programming busy timer: a pulse on start_i holds busy_o high for
// BUSY_CYC system clocks. Assumes BUSY_CYC is at least 1.
module eep_busy_timer #(
    parameter int BUSY_CYC = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o
);
    localparam int CNT_W = $clog2(BUSY_CYC + 1);

    logic [CNT_W-1:0] remain_q;

    // Load on start, count down to zero otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain_q <= '0;
        end else if (start_i) begin
            remain_q <= CNT_W'(BUSY_CYC);
        end else if (remain_q != '0) begin
            remain_q <= remain_q - 1'b1;
        end
    end

    assign busy_o = (remain_q != '0);

    // R11: a started busy period is visible on the next cycle.
    assert_busy_follows_start_R11: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> busy_o);
endmodule

// File: rtl/eep_mem.sv
// Byte array with one synchronous write port and one combinational read
// port. Contents are not reset; assumes the reader only relies on bytes
// that were written.
module eep_mem #(
    parameter int ADDR_W = 12
) (
    input  logic                      clk,
    input  logic                      we_i,
    input  logic [ADDR_W-1:0]         waddr_i,
    input  logic [eep_pkg::BYTE_W-1:0] wdata_i,
    input  logic [ADDR_W-1:0]         raddr_i,
    output logic [eep_pkg::BYTE_W-1:0] rdata_o
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [eep_pkg::BYTE_W-1:0] cells_q [DEPTH];

    // Store one byte when enabled.
    always_ff @(posedge clk) begin
        if (we_i) begin
            cells_q[waddr_i] <= wdata_i;
        end
    end

    assign rdata_o = cells_q[raddr_i];
endmodule

// File: rtl/eeprom_2w_target.sv
// Serial EEPROM target top: byte framing, select decode, address load,
// paged writes and streaming reads on top of the bus detector, busy timer
// and array. Assumes ADDR_W > 8 and PAGE_W < ADDR_W, and that the bus
// controller changes data only while the bus clock is low.
module eeprom_2w_target #(
    parameter int ADDR_W   = 12,
    parameter int PAGE_W   = 5,
    parameter int BUSY_CYC = 2000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [2:0] chip_sel_i,
    input  logic       wr_lock_i,
    output logic       sda_pull_o
);
    import eep_pkg::*;

    localparam int AHI_W = ADDR_W - BYTE_W;

    logic sda_s, scl_rise, scl_fall, start_evt, stop_evt;
    logic busy, busy_start;
    logic mem_we;
    logic [BYTE_W-1:0] mem_rdata;

    eep_state_t        state;
    logic [3:0]        bitcnt;
    logic [BYTE_W-1:0] shreg;
    logic [ADDR_W-1:0] addr;
    logic [AHI_W-1:0]  ahi;
    logic              pull;
    logic              wrote;
    logic              m_ack;
    logic              byte_done;
    logic              sel_match;

    eep_bus_sense u_sense (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .sda_o      (sda_s),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (start_evt),
        .stop_o     (stop_evt)
    );

    eep_busy_timer #(.BUSY_CYC(BUSY_CYC)) u_busy (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (busy_start),
        .busy_o  (busy)
    );

    eep_mem #(.ADDR_W(ADDR_W)) u_mem (
        .clk     (clk),
        .we_i    (mem_we),
        .waddr_i (addr),
        .wdata_i (shreg),
        .raddr_i (addr),
        .rdata_o (mem_rdata)
    );

    // Byte boundary strobe and select decode for the receive path.
    always_comb begin
        byte_done  = scl_fall && (bitcnt == 4'd8) && !start_evt && !stop_evt;
        sel_match  = (shreg[7:4] == DEV_TYPE) && (shreg[3:1] == chip_sel_i) && !busy;
        mem_we     = (state == ST_WDATA) && byte_done && !wr_lock_i;
        busy_start = stop_evt && wrote;
    end

    // Main transfer engine: framing, acknowledge and data drive.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            bitcnt <= '0;
            shreg  <= '0;
            addr   <= '0;
            ahi    <= '0;
            pull   <= 1'b0;
            wrote  <= 1'b0;
            m_ack  <= 1'b0;
        end else if (start_evt) begin
            state  <= ST_DEV;
            bitcnt <= '0;
            pull   <= 1'b0;
        end else if (stop_evt) begin
            state  <= ST_IDLE;
            bitcnt <= '0;
            pull   <= 1'b0;
            wrote  <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    pull <= 1'b0;
                end
                ST_RDATA: begin
                    if (scl_rise) begin
                        if (bitcnt < 4'd8) begin
                            bitcnt <= bitcnt + 1'b1;
                        end else if (bitcnt == 4'd8) begin
                            m_ack  <= ~sda_s;
                            bitcnt <= 4'd9;
                        end
                    end else if (scl_fall) begin
                        if (bitcnt == 4'd9) begin
                            bitcnt <= '0;
                            if (m_ack) begin
                                shreg <= mem_rdata;
                                pull  <= ~mem_rdata[7];
                                addr  <= addr + 1'b1;
                            end else begin
                                state <= ST_IDLE;
                                pull  <= 1'b0;
                            end
                        end else if (bitcnt == 4'd8) begin
                            pull <= 1'b0;
                        end else if (bitcnt != 4'd0) begin
                            pull  <= ~shreg[6];
                            shreg <= {shreg[6:0], 1'b0};
                        end
                    end
                end
                default: begin
                    if (scl_rise && bitcnt < 4'd8) begin
                        shreg  <= {shreg[6:0], sda_s};
                        bitcnt <= bitcnt + 1'b1;
                    end else if (byte_done) begin
                        bitcnt <= 4'd9;
                        case (state)
                            ST_DEV: begin
                                if (!sel_match) begin
                                    state <= ST_IDLE;
                                    pull  <= 1'b0;
                                end else begin
                                    pull  <= 1'b1;
                                    m_ack <= 1'b1;
                                    state <= shreg[0] ? ST_RDATA : ST_AHI;
                                end
                            end
                            ST_AHI: begin
                                ahi   <= shreg[AHI_W-1:0];
                                pull  <= 1'b1;
                                state <= ST_ALO;
                            end
                            ST_ALO: begin
                                addr  <= {ahi, shreg};
                                pull  <= 1'b1;
                                state <= ST_WDATA;
                            end
                            default: begin
                                if (wr_lock_i) begin
                                    pull  <= 1'b0;
                                    state <= ST_IDLE;
                                end else begin
                                    pull  <= 1'b1;
                                    wrote <= 1'b1;
                                    addr  <= {addr[ADDR_W-1:PAGE_W],
                                              PAGE_W'(addr[PAGE_W-1:0] + 1'b1)};
                                end
                            end
                        endcase
                    end else if (scl_fall && bitcnt == 4'd9) begin
                        bitcnt <= '0;
                        pull   <= 1'b0;
                    end
                end
            endcase
        end
    end

    assign sda_pull_o = pull;

    // R12: the data pull only moves after a clock fall, Start or Stop.
    assert_pull_moves_on_fall_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_pull_o) |-> $past(scl_fall || start_evt || stop_evt));

    // R1: a Start always leaves the bus released.
    assert_start_releases_R1: assert property (@(posedge clk) disable iff (!rst_n)
        start_evt |=> !sda_pull_o);

    // R11: a select seen while busy is never acknowledged.
    assert_busy_no_ack_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DEV && byte_done && busy) |=> !sda_pull_o);

    // R7: a locked data byte is never acknowledged.
    assert_locked_no_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WDATA && byte_done && wr_lock_i) |=> !sda_pull_o);

    // R6: while data streams in, the page bits of the address hold.
    assert_page_upper_fixed_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WDATA && $past(state) == ST_WDATA)
        |-> (addr[ADDR_W-1:PAGE_W] == $past(addr[ADDR_W-1:PAGE_W])));
endmodule

// File: tb/eeprom_2w_target_bench.sv
// Scoreboard bench: the driver pushes expected read bytes, a monitor pops
// and compares them with bytes observed on the bus.
module eeprom_2w_target_bench;
    localparam int         CLK_PERIOD = 10;
    localparam int         Q          = 8;
    localparam int         BUSY       = 400;
    localparam logic [2:0] CS         = 3'b101;
    localparam logic [7:0] SEL_W      = {4'b1010, CS, 1'b0};
    localparam logic [7:0] SEL_R      = {4'b1010, CS, 1'b1};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1;
    logic       sda_m = 1'b1;
    logic       wr_lock = 1'b0;
    logic [2:0] chip_sel = CS;
    logic       sda_pull;
    logic       sda_line;

    int checks = 0;
    int errors = 0;
    int r12_viol = 0;
    bit done = 1'b0;

    logic [7:0] exp_q [$];
    logic [7:0] obs_q [$];
    string      tag_q [$];

    assign sda_line = sda_m & ~sda_pull;

    eeprom_2w_target #(.ADDR_W(12), .PAGE_W(5), .BUSY_CYC(BUSY)) u_eeprom_2w_target (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl),
        .sda_i      (sda_line),
        .chip_sel_i (chip_sel),
        .wr_lock_i  (wr_lock),
        .sda_pull_o (sda_pull)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check_eq(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wait_q();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wait_q(); scl = 1'b1; wait_q();
        sda_m = 1'b0; wait_q(); scl = 1'b0; wait_q();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wait_q(); scl = 1'b1; wait_q();
        sda_m = 1'b1; wait_q();
    endtask

    task automatic tx_byte(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wait_q(); scl = 1'b1; wait_q(); wait_q(); scl = 1'b0;
        end
        sda_m = 1'b1; wait_q(); scl = 1'b1; wait_q();
        ack = !sda_line;
        wait_q(); scl = 1'b0;
    endtask

    task automatic rx_byte(input bit mack, output logic [7:0] d);
        sda_m = 1'b1;
        d = '0;
        for (int i = 0; i < 8; i++) begin
            wait_q(); scl = 1'b1; wait_q();
            d = {d[6:0], sda_line};
            wait_q(); scl = 1'b0;
        end
        sda_m = mack ? 1'b0 : 1'b1;
        wait_q(); scl = 1'b1; wait_q(); wait_q(); scl = 1'b0;
        sda_m = 1'b1;
    endtask

    task automatic expect_byte(input string tag, input logic [7:0] v);
        exp_q.push_back(v);
        tag_q.push_back(tag);
    endtask

    task automatic wait_busy();
        repeat (BUSY + 60) @(negedge clk);
    endtask

    task automatic send_addr(input logic [7:0] hi, input logic [7:0] lo);
        bit ack;
        tx_byte(SEL_W, ack); check_eq("R2 select write", int'(ack), 1);
        tx_byte(hi, ack);    check_eq("R4 addr hi", int'(ack), 1);
        tx_byte(lo, ack);    check_eq("R4 addr lo", int'(ack), 1);
    endtask

    task automatic byte_write(input logic [7:0] hi, input logic [7:0] lo, input logic [7:0] v);
        bit ack;
        bus_start();
        send_addr(hi, lo);
        tx_byte(v, ack); check_eq("R5 data ack", int'(ack), 1);
        bus_stop();
        wait_busy();
    endtask

    task automatic rand_read(input logic [11:0] a, input int n, input bit tail);
        bit ack;
        logic [7:0] d;
        bus_start();
        send_addr({4'h0, a[11:8]}, a[7:0]);
        bus_start();
        tx_byte(SEL_R, ack); check_eq("R3 select read", int'(ack), 1);
        for (int i = 0; i < n; i++) begin
            rx_byte(i < n - 1, d);
            obs_q.push_back(d);
        end
        if (tail) begin
            rx_byte(1'b0, d);
            obs_q.push_back(d);
        end
        bus_stop();
    endtask

    // Monitor: pop and compare expected against observed bytes.
    always @(negedge clk) begin
        if (obs_q.size() != 0 && exp_q.size() != 0) begin
            logic [7:0] o, e;
            string t;
            o = obs_q.pop_front();
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check_eq(t, int'(o), int'(e));
        end
    end

    // R12 watch: the pull must hold while the bus clock stays high.
    logic scl_d = 1'b1;
    logic pull_d = 1'b0;
    always @(negedge clk) begin
        if (rst_n && scl && scl_d && (sda_pull != pull_d) && !done) r12_viol++;
        scl_d  <= scl;
        pull_d <= sda_pull;
    end

    // Watchdog.
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        bit ack;
        logic [7:0] d;
        repeat (5) @(negedge clk);
        check_eq("R12 reset pull", int'(sda_pull), 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R2: wrong chip bits, then a following byte, then wrong type code.
        bus_start();
        tx_byte({4'b1010, 3'b011, 1'b0}, ack); check_eq("R2 chip mismatch", int'(ack), 0);
        tx_byte(8'h00, ack);                  check_eq("R2 standby byte", int'(ack), 0);
        bus_stop();
        bus_start();
        tx_byte({4'b1011, CS, 1'b0}, ack);     check_eq("R2 type mismatch", int'(ack), 0);
        bus_stop();

        // R5 byte write, then R11 busy select.
        bus_start();
        send_addr(8'h01, 8'h23);
        tx_byte(8'h5A, ack); check_eq("R5 data ack", int'(ack), 1);
        bus_stop();
        bus_start();
        tx_byte(SEL_W, ack); check_eq("R11 busy select", int'(ack), 0);
        bus_stop();
        wait_busy();

        // R9 random read.
        expect_byte("R9 random read", 8'h5A);
        rand_read(12'h123, 1, 1'b0);

        // R4 upper address bits ignored.
        byte_write(8'hF1, 8'h40, 8'h11);
        expect_byte("R4 upper ignored", 8'h11);
        rand_read(12'h140, 1, 1'b0);

        // R6 page wrap across the end of page 0x2E0.
        bus_start();
        send_addr(8'h02, 8'hFC);
        for (int i = 0; i < 6; i++) begin
            tx_byte(8'hA0 + 8'(i), ack); check_eq("R6 page data ack", int'(ack), 1);
        end
        bus_stop();
        wait_busy();
        for (int i = 0; i < 4; i++) expect_byte("R6 page tail", 8'hA0 + 8'(i));
        rand_read(12'h2FC, 4, 1'b0);
        expect_byte("R6 page wrap", 8'hA4);
        expect_byte("R6 page wrap", 8'hA5);
        rand_read(12'h2E0, 2, 1'b0);

        // R6 overwrite: 34 bytes into one page.
        bus_start();
        send_addr(8'h04, 8'h00);
        for (int i = 0; i < 34; i++) begin
            tx_byte(8'h30 + 8'(i), ack);
        end
        check_eq("R6 last data ack", int'(ack), 1);
        bus_stop();
        wait_busy();
        expect_byte("R6 overwrite", 8'h50);
        expect_byte("R6 overwrite", 8'h51);
        expect_byte("R6 kept", 8'h32);
        rand_read(12'h400, 3, 1'b0);

        // R8 current-address read continues from the pointer.
        expect_byte("R8 current read", 8'h33);
        bus_start();
        tx_byte(SEL_R, ack); check_eq("R8 select read", int'(ack), 1);
        rx_byte(1'b0, d);
        obs_q.push_back(d);
        bus_stop();

        // R10 sequential read wraps the full address; nack releases bus.
        byte_write(8'h0F, 8'hFF, 8'h77);
        byte_write(8'h00, 8'h00, 8'h66);
        expect_byte("R10 seq first", 8'h77);
        expect_byte("R10 seq wrap", 8'h66);
        expect_byte("R10 released after nack", 8'hFF);
        rand_read(12'hFFF, 2, 1'b1);

        // R7 locked write leaves the array unchanged; no busy follows.
        wr_lock = 1'b1;
        bus_start();
        send_addr(8'h01, 8'h23);
        tx_byte(8'hEE, ack); check_eq("R7 locked data nack", int'(ack), 0);
        bus_stop();
        wr_lock = 1'b0;
        bus_start();
        tx_byte(SEL_W, ack); check_eq("R11 no busy after locked write", int'(ack), 1);
        tx_byte(8'h01, ack);
        tx_byte(8'h23, ack);
        bus_start();
        tx_byte(SEL_R, ack);
        rx_byte(1'b0, d);
        expect_byte("R7 array unchanged", 8'h5A);
        obs_q.push_back(d);
        bus_stop();

        // R1: byte without a Start after Stop is ignored; Start restores.
        bus_start();
        send_addr(8'h00, 8'h50);
        bus_stop();
        tx_byte(SEL_W, ack); check_eq("R1 no start no ack", int'(ack), 0);
        bus_start();
        tx_byte(SEL_W, ack); check_eq("R1 start then ack", int'(ack), 1);
        bus_stop();

        repeat (20) @(negedge clk);
        check_eq("R8 scoreboard drained", exp_q.size() + obs_q.size(), 0);
        check_eq("R12 pull moved while clock high", r12_viol, 0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule